// File: doc/BRIEF.md
# USB Host Interrupt Status Aggregator

This block gathers every interrupt cause of a USB host controller into one read-only 32-bit status word and drives a single interrupt request line. Port and frame logic deliver one-cycle event pulses (device attached, device removed, bus reset sent, downstream resume sent, upstream resume received, frame start, low-speed keep-alive). Each pulse sets a sticky bit that software clears by writing ones to a clear register. Pipe and DMA channel interrupts arrive as levels. Their status bits follow the source one cycle later and fall when the source is served, so the clear register cannot touch them.

A wakeup bit records an upstream resume or a disconnection seen on the line while the host is suspended (frame generation off). Capture uses an asynchronous set, so the event is held even when the main clock is stopped. The captured value passes through a two-flop synchronizer before it is read. A mask register is written through separate set and clear addresses. The request line is a registered OR of all masked status bits.

Register map (word addresses on `reg_addr_i`): 0 status (read), 1 clear (write ones), 2 mask set (write ones), 3 mask clear (write ones), 4 mask (read). All other reads return zero.

Top module: `usb_host_irq_agg`

## Requirements
- R1: After reset the status word reads 0x00000000, the mask reads 0x00000000 and `irq_o` is 0.
- R2: Sticky status bits: bit 0 device attached (`ev_conn_i`), bit 1 device removed (`ev_disc_i`), bit 2 bus reset sent, bit 3 downstream resume sent, bit 4 upstream resume received, bit 5 frame start. A pulse sampled at a clock edge shows in the status read after that edge. Bits 7 and 18 to 24 always read 0.
- R3: A write to address 1 clears each of status bits 0 to 6 whose write-data bit is 1 and leaves the others unchanged. A write to address 0 changes nothing.
- R4: If an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: Bit 5 is set by `ev_sof_i`. It is also set by `ev_keepalive_i`, but only while `low_speed_i` is 1.
- R6: Status bits 8 to 17 equal `pipe_irq_i[0..9]` as sampled at the previous clock edge. Writes to the clear register do not change them.
- R7: Status bits 25 to 31 equal `dma_irq_i[0..6]` as sampled at the previous clock edge. Writes to the clear register do not change them.
- R8: Bit 6 is set when `sof_en_i` is 0 and `wk_resume_i` or `wk_disc_i` rises. It reads 1 no later than the second clock edge after the capture. When `sof_en_i` is 1 these inputs have no effect. The bit is cleared by writing 1 to bit 6 of the clear register.
- R9: A wakeup line event that occurs while the clock is stopped is held. It reads as bit 6 after the clock restarts.
- R10: Writing ones to address 2 sets those mask bits, and writing ones to address 3 clears them. Other mask bits are kept. If the same bit is written to both addresses in the same cycle, the set wins. The mask reads back at address 4.
- R11: After every clock edge, `irq_o` equals the OR over all bits of (status AND mask) as it stood just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock (may be stopped) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sof_en_i | input | 1 | Frame generation enabled; 0 means suspended |
| low_speed_i | input | 1 | Host running in low-speed mode |
| ev_conn_i | input | 1 | Device attached pulse |
| ev_disc_i | input | 1 | Device removed pulse |
| ev_rst_sent_i | input | 1 | Bus reset sent pulse |
| ev_rsm_sent_i | input | 1 | Downstream resume sent pulse |
| ev_rsm_rcvd_i | input | 1 | Upstream resume received pulse |
| ev_sof_i | input | 1 | Frame start issued pulse |
| ev_keepalive_i | input | 1 | Low-speed keep-alive sent pulse |
| wk_resume_i | input | 1 | Asynchronous upstream resume detect |
| wk_disc_i | input | 1 | Asynchronous disconnection detect |
| pipe_irq_i | input | NUM_PIPES | Per-pipe interrupt levels |
| dma_irq_i | input | NUM_DMA | Per-DMA-channel interrupt levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle. A sticky bit stays set until a matching clear. An event pulse always sets its bit, even against a clear in the same cycle. Pipe and DMA bits track their sources with a one-cycle lag. Mask set and clear writes land. The request line matches the masked status of the previous cycle. The bench scenarios cover the rest: the wakeup path across a stopped clock, wakeup inputs being ignored while frames run, the keep-alive dependence on speed mode, and clear writes aimed at the level-following bits.

// File: rtl/usb_hirq_pkg.sv
package usb_hirq_pkg;
  localparam int unsigned STAT_W   = 32;
  localparam int unsigned EVT_N    = 6;
  localparam int unsigned WAKE_BIT = 6;
  localparam int unsigned PIPE_LSB = 8;
  localparam int unsigned ADDR_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 3'd0,
    A_CLEAR  = 3'd1,
    A_MSET   = 3'd2,
    A_MCLR   = 3'd3,
    A_MASK   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/hirq_event_bank.sv
module hirq_event_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    // set has priority so no event is dropped
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;
      else if (clr_i[g]) q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/hirq_wake_capture.sv
module hirq_wake_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic suspend_i,
  input  logic resume_i,
  input  logic disc_i,
  input  logic clr_i,
  output logic wake_o
);
  logic wake_req;
  logic cap_q, s1_q, s2_q;

  assign wake_req = suspend_i & (resume_i | disc_i);

  // asynchronous set keeps the event while clk_i is stopped
  always_ff @(posedge clk_i or negedge rst_ni or posedge wake_req) begin
    if (!rst_ni)       cap_q <= 1'b0;
    else if (wake_req) cap_q <= 1'b1;
    else if (clr_i)    cap_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else if (clr_i) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= cap_q;
      s2_q <= s1_q;
    end
  end

  assign wake_o = s2_q;
endmodule

// File: rtl/hirq_mask_reg.sv
module hirq_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] set_v, clr_v;

  assign set_v = set_we_i ? wdata_i : '0;
  assign clr_v = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else         mask_o <= (mask_o & ~clr_v) | set_v;
  end
endmodule

// File: rtl/hirq_level_stage.sv
module hirq_level_stage #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/usb_host_irq_agg.sv
module usb_host_irq_agg
  import usb_hirq_pkg::*;
#(
  parameter int unsigned NUM_PIPES = 10,
  parameter int unsigned NUM_DMA   = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sof_en_i,
  input  logic                 low_speed_i,
  input  logic                 ev_conn_i,
  input  logic                 ev_disc_i,
  input  logic                 ev_rst_sent_i,
  input  logic                 ev_rsm_sent_i,
  input  logic                 ev_rsm_rcvd_i,
  input  logic                 ev_sof_i,
  input  logic                 ev_keepalive_i,
  input  logic                 wk_resume_i,
  input  logic                 wk_disc_i,
  input  logic [NUM_PIPES-1:0] pipe_irq_i,
  input  logic [NUM_DMA-1:0]   dma_irq_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [STAT_W-1:0]    reg_wdata_i,
  output logic [STAT_W-1:0]    reg_rdata_o,
  output logic                 irq_o
);
  localparam int unsigned DMA_LSB = STAT_W - NUM_DMA;

  logic [EVT_N-1:0]     evt_vec;
  logic [WAKE_BIT:0]    clr_vec;
  logic [EVT_N-1:0]     stk_q;
  logic                 wake_w;
  logic [NUM_PIPES-1:0] pipe_q;
  logic [NUM_DMA-1:0]   dma_q;
  logic [STAT_W-1:0]    mask_q;
  logic [STAT_W-1:0]    status_w;
  logic                 irq_q;

  assign evt_vec = {ev_sof_i | (ev_keepalive_i & low_speed_i),
                    ev_rsm_rcvd_i, ev_rsm_sent_i, ev_rst_sent_i,
                    ev_disc_i, ev_conn_i};

  assign clr_vec = (reg_we_i && reg_addr_i == A_CLEAR) ? reg_wdata_i[WAKE_BIT:0] : '0;

  hirq_event_bank #(.N(EVT_N)) u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_vec),
    .clr_i (clr_vec[EVT_N-1:0]),
    .q_o   (stk_q)
  );

  hirq_wake_capture u_wake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .suspend_i(~sof_en_i),
    .resume_i (wk_resume_i),
    .disc_i   (wk_disc_i),
    .clr_i    (clr_vec[WAKE_BIT]),
    .wake_o   (wake_w)
  );

  hirq_level_stage #(.W(NUM_PIPES)) u_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pipe_irq_i),
    .q_o   (pipe_q)
  );

  hirq_level_stage #(.W(NUM_DMA)) u_dma (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dma_irq_i),
    .q_o   (dma_q)
  );

  hirq_mask_reg #(.W(STAT_W)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_we_i(reg_we_i && reg_addr_i == A_MSET),
    .clr_we_i(reg_we_i && reg_addr_i == A_MCLR),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask_q)
  );

  always_comb begin
    status_w                          = '0;
    status_w[EVT_N-1:0]               = stk_q;
    status_w[WAKE_BIT]                = wake_w;
    status_w[PIPE_LSB +: NUM_PIPES]   = pipe_q;
    status_w[DMA_LSB +: NUM_DMA]      = dma_q;
  end

  always_comb begin
    case (reg_addr_i)
      A_STATUS: reg_rdata_o = status_w;
      A_MASK:   reg_rdata_o = mask_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_w & mask_q);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/hirq_checker.sv
module hirq_checker
  import usb_hirq_pkg::*;
#(
  parameter int unsigned NUM_PIPES = 10,
  parameter int unsigned NUM_DMA   = 7
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 low_speed_i,
  input logic                 ev_conn_i,
  input logic                 ev_disc_i,
  input logic                 ev_rst_sent_i,
  input logic                 ev_rsm_sent_i,
  input logic                 ev_rsm_rcvd_i,
  input logic                 ev_sof_i,
  input logic                 ev_keepalive_i,
  input logic [NUM_PIPES-1:0] pipe_irq_i,
  input logic [NUM_DMA-1:0]   dma_irq_i,
  input logic                 reg_we_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [STAT_W-1:0]    reg_wdata_i,
  input logic [STAT_W-1:0]    status_i,
  input logic [STAT_W-1:0]    mask_i,
  input logic                 irq_o
);
  localparam int unsigned DMA_LSB = STAT_W - NUM_DMA;

  logic armed;
  logic [EVT_N-1:0]  evt_v;
  logic [EVT_N-1:0]  clr_v;
  logic [STAT_W-1:0] mset_v, mclr_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assign evt_v  = {ev_sof_i | (ev_keepalive_i & low_speed_i), ev_rsm_rcvd_i,
                   ev_rsm_sent_i, ev_rst_sent_i, ev_disc_i, ev_conn_i};
  assign clr_v  = (reg_we_i && reg_addr_i == A_CLEAR) ? reg_wdata_i[EVT_N-1:0] : '0;
  assign mset_v = (reg_we_i && reg_addr_i == A_MSET) ? reg_wdata_i : '0;
  assign mclr_v = (reg_we_i && reg_addr_i == A_MCLR) ? reg_wdata_i : '0;

  p_sticky_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (($past(status_i[EVT_N-1:0]) & ~$past(clr_v) & ~status_i[EVT_N-1:0]) == '0));

  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (($past(evt_v) & ~status_i[EVT_N-1:0]) == '0));

  p_pipe_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (status_i[PIPE_LSB +: NUM_PIPES] == $past(pipe_irq_i)));

  p_dma_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (status_i[DMA_LSB +: NUM_DMA] == $past(dma_irq_i)));

  p_mask_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (($past(mset_v) & ~mask_i) == '0));

  p_mask_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (($past(mclr_v & ~mset_v) & mask_i) == '0));

  p_irq_track_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (irq_o == $past(|(status_i & mask_i))));
endmodule

bind usb_host_irq_agg hirq_checker #(.NUM_PIPES(NUM_PIPES), .NUM_DMA(NUM_DMA)) u_hirq_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .low_speed_i   (low_speed_i),
  .ev_conn_i     (ev_conn_i),
  .ev_disc_i     (ev_disc_i),
  .ev_rst_sent_i (ev_rst_sent_i),
  .ev_rsm_sent_i (ev_rsm_sent_i),
  .ev_rsm_rcvd_i (ev_rsm_rcvd_i),
  .ev_sof_i      (ev_sof_i),
  .ev_keepalive_i(ev_keepalive_i),
  .pipe_irq_i    (pipe_irq_i),
  .dma_irq_i     (dma_irq_i),
  .reg_we_i      (reg_we_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .status_i      (status_w),
  .mask_i        (mask_q),
  .irq_o         (irq_o)
);

// File: tb/usb_host_irq_agg_bench.sv
`timescale 1ns/1ps
module usb_host_irq_agg_bench;
  logic        clk = 1'b0;
  logic        clk_run = 1'b1;
  logic        rst_n = 1'b0;
  logic        sof_en = 1'b1, low_speed = 1'b0;
  logic        e_conn = 0, e_disc = 0, e_rst = 0, e_rsent = 0, e_rrcvd = 0, e_sof = 0, e_ka = 0;
  logic        wk_rsm = 0, wk_dsc = 0;
  logic [9:0]  pipe = '0;
  logic [6:0]  dma = '0;
  logic        we = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  // bench model
  logic [5:0]  m_stk = '0;
  logic        m_wake = 0;
  logic [9:0]  m_pipe = '0;
  logic [6:0]  m_dma = '0;
  logic [31:0] m_mask = '0;
  logic        m_irq = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  usb_host_irq_agg u_usb_host_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .sof_en_i(sof_en), .low_speed_i(low_speed),
    .ev_conn_i(e_conn), .ev_disc_i(e_disc), .ev_rst_sent_i(e_rst),
    .ev_rsm_sent_i(e_rsent), .ev_rsm_rcvd_i(e_rrcvd), .ev_sof_i(e_sof),
    .ev_keepalive_i(e_ka), .wk_resume_i(wk_rsm), .wk_disc_i(wk_dsc),
    .pipe_irq_i(pipe), .dma_irq_i(dma), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  initial forever begin
    #5;
    if (clk_run) clk = ~clk;
  end

  function automatic logic [31:0] m_status();
    return {m_dma, 7'b0, m_pipe, 1'b0, m_wake, m_stk};
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    if (a == 3'd0) return m_status();
    if (a == 3'd4) return m_mask;
    return 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // called just after a falling edge with inputs set; returns after next falling edge
  task automatic tick(input bit chk, input string req);
    logic [5:0]  evt;
    logic [6:0]  clr;
    logic [31:0] ms, mc;
    logic        nirq;
    #1;
    if (chk) begin
      check(req, rdata, m_read(addr));
      check("R11", {31'b0, irq}, {31'b0, m_irq});
    end
    @(posedge clk);
    evt  = {e_sof | (e_ka & low_speed), e_rrcvd, e_rsent, e_rst, e_disc, e_conn};
    clr  = (we && addr == 3'd1) ? wdata[6:0] : 7'h0;
    ms   = (we && addr == 3'd2) ? wdata : 32'h0;
    mc   = (we && addr == 3'd3) ? wdata : 32'h0;
    nirq = |(m_status() & m_mask);
    m_stk  = (m_stk & ~clr[5:0]) | evt;
    if (!(!sof_en && (wk_rsm || wk_dsc))) m_wake = m_wake & ~clr[6];
    m_pipe = pipe;
    m_dma  = dma;
    m_mask = (m_mask & ~mc) | ms;
    m_irq  = nirq;
    @(negedge clk);
  endtask

  task automatic idle();
    {e_conn, e_disc, e_rst, e_rsent, e_rrcvd, e_sof, e_ka} = '0;
    we = 0;
    wdata = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string req);
    we = 1; addr = a; wdata = d;
    tick(1, req);
    idle();
    addr = 3'd0;
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
    #1;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(3'd0, "R1", 32'h0);
    rd(3'd4, "R1", 32'h0);
    check("R1", {31'b0, irq}, 32'h0);
    addr = 3'd0;

    // R2 each sticky event
    e_conn = 1; tick(1, "R2"); idle(); rd(3'd0, "R2", 32'h01);
    e_disc = 1; tick(1, "R2"); idle(); rd(3'd0, "R2", 32'h03);
    e_rst = 1; e_rsent = 1; tick(1, "R2"); idle(); rd(3'd0, "R2", 32'h0F);
    e_rrcvd = 1; e_sof = 1; tick(1, "R2"); idle(); rd(3'd0, "R2", 32'h3F);

    // R3 status write ignored, selective clear
    wr(3'd0, 32'hFFFF_FFFF, "R3");
    rd(3'd0, "R3", 32'h3F);
    wr(3'd1, 32'h0000_0005, "R3");
    rd(3'd0, "R3", 32'h3A);

    // R4 set beats clear
    e_disc = 1; wr(3'd1, 32'h0000_0002, "R4");
    rd(3'd0, "R4", 32'h3A);

    // R5 keep-alive depends on speed mode
    wr(3'd1, 32'h7F, "R5");
    rd(3'd0, "R5", 32'h0);
    e_ka = 1; low_speed = 0; tick(1, "R5"); idle();
    rd(3'd0, "R5", 32'h0);
    e_ka = 1; low_speed = 1; tick(1, "R5"); idle();
    rd(3'd0, "R5", 32'h20);
    low_speed = 0;
    wr(3'd1, 32'h20, "R5");

    // R6 pipe bits follow source, clear ignored
    pipe = 10'h2A5; tick(1, "R6");
    rd(3'd0, "R6", 32'h0002_A500);
    wr(3'd1, 32'hFFFF_FFFF, "R6");
    rd(3'd0, "R6", 32'h0002_A500);
    pipe = '0; tick(1, "R6");
    rd(3'd0, "R6", 32'h0);

    // R7 DMA bits follow source, clear ignored
    dma = 7'h55; tick(1, "R7");
    rd(3'd0, "R7", 32'hAA00_0000);
    wr(3'd1, 32'hFFFF_FFFF, "R7");
    rd(3'd0, "R7", 32'hAA00_0000);

    // R2 reserved bits stay zero with everything set
    pipe = 10'h3FF; dma = 7'h7F;
    e_conn = 1; e_disc = 1; e_rst = 1; e_rsent = 1; e_rrcvd = 1; e_sof = 1;
    tick(1, "R2"); idle();
    rd(3'd0, "R2", 32'hFE03_FF3F);
    pipe = '0; dma = '0;
    wr(3'd1, 32'h7F, "R2");
    tick(1, "R2");
    rd(3'd0, "R2", 32'h0);

    // R10 mask set/clear, R11 irq timing
    wr(3'd2, 32'h0000_0021, "R10");
    rd(3'd4, "R10", 32'h21);
    wr(3'd3, 32'h0000_0001, "R10");
    rd(3'd4, "R10", 32'h20);
    we = 1; addr = 3'd2; wdata = 32'h8; tick(1, "R10");
    we = 1; addr = 3'd3; wdata = 32'h8; tick(1, "R10");
    idle(); addr = 3'd4; tick(1, "R10");
    rd(3'd4, "R10", 32'h20);
    addr = 3'd0;
    e_sof = 1; tick(1, "R11"); idle();
    check("R11", {31'b0, irq}, 32'h0);
    tick(1, "R11");
    check("R11", {31'b0, irq}, 32'h1);
    wr(3'd1, 32'h20, "R11");
    check("R11", {31'b0, irq}, 32'h1);
    tick(1, "R11");
    check("R11", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'hFFFF_FFFF, "R11");

    // R8 ignored while frames run
    sof_en = 1; wk_rsm = 1; #2; wk_rsm = 0; wk_dsc = 1; #2; wk_dsc = 0;
    repeat (4) tick(1, "R8");
    rd(3'd0, "R8", 32'h0);

    // R8 set while suspended via disconnection, then clear
    wr(3'd2, 32'h40, "R8");
    sof_en = 0; wk_dsc = 1; #2; wk_dsc = 0;
    repeat (3) tick(0, "R8");
    m_wake = 1;
    tick(0, "R8");
    rd(3'd0, "R8", 32'h40);
    check("R8", {31'b0, irq}, 32'h1);
    wr(3'd1, 32'h40, "R8");
    rd(3'd0, "R8", 32'h0);
    tick(1, "R8");

    // R9 capture with clock stopped
    clk_run = 0;
    #40; wk_rsm = 1; #7; wk_rsm = 0; #40;
    clk_run = 1;
    repeat (3) tick(0, "R9");
    m_wake = 1;
    tick(0, "R9");
    rd(3'd0, "R9", 32'h40);
    check("R9", {31'b0, irq}, 32'h1);
    wr(3'd1, 32'h40, "R9");
    rd(3'd0, "R9", 32'h0);
    wr(3'd3, 32'hFFFF_FFFF, "R9");
    sof_en = 1;

    // random phase
    for (int i = 0; i < 3000; i++) begin
      e_conn  = ($urandom % 8) == 0;
      e_disc  = ($urandom % 8) == 0;
      e_rst   = ($urandom % 8) == 0;
      e_rsent = ($urandom % 8) == 0;
      e_rrcvd = ($urandom % 8) == 0;
      e_sof   = ($urandom % 6) == 0;
      e_ka    = ($urandom % 6) == 0;
      low_speed = ($urandom % 2) == 0;
      if (($urandom % 4) == 0) pipe = pipe ^ 10'($urandom);
      if (($urandom % 4) == 0) dma  = dma ^ 7'($urandom);
      we    = ($urandom % 3) == 0;
      addr  = 3'($urandom % 6);
      wdata = $urandom;
      tick(1, addr == 3'd4 ? "R10" : "R3");
    end
    idle();
    tick(1, "R3");

    done = 1;
    summary();
    $finish;
  end
endmodule